// File: doc/BRIEF.md
# Synthesizer Divider Word Loader

This block programs the dividers of an external frequency synthesizer over a three-wire serial link made of a shift clock, a data line and a load strobe. The synthesizer keeps two 19-bit registers. One holds the 14-bit reference divide ratio together with a few fixed operating bits. The other holds the 11-bit main counter and the 7-bit swallow counter. The last bit shifted into the synthesizer tells it which register the word is for.

A host presents the reference, main and swallow values, selects one or both words, and pulses `start`. The block captures the values, assembles each word and shifts it out most significant bit first with one rising shift-clock edge per bit. It then raises the load strobe to latch the word. Every interval on the link lasts a parameterised number of system clocks, with a minimum of one. The data setup before a rising edge, the clock high time, the gap between the last clock and the strobe, and the strobe width can therefore be set to the synthesizer's minimum timings at any system clock rate. When both words are requested, the reference word goes first. `busy` covers the whole request, and `done` pulses once per latched word.

Top module: `synth_word_loader`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sclk`, `sdata`, `sle`, `busy` and `done` are all 0.
- R2: The reference word, in shift order, is: charge-pump select 0, lock-detect output select 0, phase polarity 1, a reserved 0, the 14 reference bits from most to least significant, and a final 1.
- R3: The counter word, in shift order, is: the 11 main-counter bits from most to least significant, the 7 swallow bits from most to least significant, and a final 0.
- R4: Each word is shifted most significant bit first, with exactly 19 rising edges of `sclk`. `sle` stays low while `sclk` is high and throughout the shifting.
- R5: `sdata` is held for at least DSU_CYC cycles before each rising `sclk` edge and does not change while `sclk` is high. `sclk` is high for exactly CHI_CYC cycles per bit.
- R6: `sle` rises no earlier than GAP_CYC cycles after the last falling edge of `sclk` and stays high for exactly LE_CYC cycles.
- R7: When both words are requested, the reference word is latched first and the counter word second.
- R8: A `start` while `busy` is high is ignored, and so are any value changes at that time. The words sent carry the values captured when the request was accepted.
- R9: A `start` with neither word selected is ignored. `busy` stays 0 and the link stays quiet.
- R10: `done` is high for exactly one cycle per word: the first cycle in which `sle` is low again after the strobe.
- R11: `busy` is 1 from the cycle after an accepted `start` until the cycle in which the final `done` is high, where it reads 0. A new `start` in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled while idle |
| want_ref | input | 1 | Send the reference word |
| want_cnt | input | 1 | Send the counter word |
| ref_div | input | R_W (14) | Reference divide ratio |
| main_div | input | N_W (11) | Main counter value |
| swal_div | input | A_W (7) | Swallow counter value |
| sclk | output | 1 | Serial shift clock to the synthesizer |
| sdata | output | 1 | Serial data to the synthesizer |
| sle | output | 1 | Load strobe to the synthesizer |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse after each word is latched |

## Verification
Completion and acceptance can fall in the same cycle. The `done` pulse of the final word coincides with `busy` dropping, and a new `start` presented in exactly that cycle must be taken. The bench waits for `busy` to fall, checks that `done` is high in that cycle, and drives the next request at once. It then checks that `busy` rises in the next cycle and that both requests' words come out complete and in order. A second collision, a `start` with altered values arriving while a transfer is running, is judged by comparing the captured words against the values from the accepted request.

// File: rtl/spw_pkg.sv
package spw_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_HIGH,
      PH_GAP,
      PH_LATCH
   } phase_t;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/spw_interval.sv
module spw_interval #(
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] val,
   output logic          expired
);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= val;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/spw_word_fmt.sv
module spw_word_fmt #(
   parameter int R_W       = 14,
   parameter int N_W       = 11,
   parameter int A_W       = 7,
   parameter bit PUMP_SEL  = 1'b0,
   parameter bit LD_SEL    = 1'b0,
   parameter bit PHASE_POL = 1'b1,
   parameter bit RSV_BIT   = 1'b0,
   localparam int WORD_W   = N_W + A_W + 1
) (
   input  logic [R_W-1:0]    r_val,
   input  logic [N_W-1:0]    n_val,
   input  logic [A_W-1:0]    a_val,
   output logic [WORD_W-1:0] ref_word,
   output logic [WORD_W-1:0] cnt_word
);
   generate
      if (R_W + 5 != WORD_W) begin : g_bad_ref_len
         $error("reference word length differs from counter word length");
      end
   endgenerate

   // trailing bit selects the destination register: 1 reference, 0 counter
   assign ref_word = {PUMP_SEL, LD_SEL, PHASE_POL, RSV_BIT, r_val, 1'b1};
   assign cnt_word = {n_val, a_val, 1'b0};
endmodule

// File: rtl/spw_shreg.sv
module spw_shreg #(
   parameter int W = 19
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         shift,
   input  logic [W-1:0] word,
   output logic         msb
);
   logic [W-1:0] sr;

   always_ff @(posedge clk) begin
      if (!rst_n)      sr <= '0;
      else if (load)   sr <= word;
      else if (shift)  sr <= {sr[W-2:0], 1'b0};
   end

   assign msb = sr[W-1];
endmodule

// File: rtl/synth_word_loader.sv
module synth_word_loader #(
   parameter int R_W     = 14,
   parameter int N_W     = 11,
   parameter int A_W     = 7,
   parameter int DSU_CYC = 5,
   parameter int CHI_CYC = 2,
   parameter int GAP_CYC = 5,
   parameter int LE_CYC  = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           want_ref,
   input  logic           want_cnt,
   input  logic [R_W-1:0] ref_div,
   input  logic [N_W-1:0] main_div,
   input  logic [A_W-1:0] swal_div,
   output logic           sclk,
   output logic           sdata,
   output logic           sle,
   output logic           busy,
   output logic           done
);
   import spw_pkg::*;

   localparam int WORD_W = N_W + A_W + 1;
   localparam int BIT_W  = $clog2(WORD_W);
   localparam int MAXC   = imax(imax(DSU_CYC, CHI_CYC), imax(GAP_CYC, LE_CYC));
   localparam int TW     = $clog2(MAXC + 1);

   generate
      if (DSU_CYC < 1 || CHI_CYC < 1 || GAP_CYC < 1 || LE_CYC < 1) begin : g_bad_timing
         $error("every link interval needs at least one system clock");
      end
      if (WORD_W != 19) begin : g_bad_word
         $error("synthesizer words are 19 bits long");
      end
   endgenerate

   phase_t            ph;
   logic [BIT_W-1:0]  bit_idx;
   logic              pend;
   logic [R_W-1:0]    r_q;
   logic [N_W-1:0]    n_q;
   logic [A_W-1:0]    a_q;
   logic              sclk_q, sle_q, done_q;

   logic              accept, last_bit, expired;
   logic              tmr_load;
   logic [TW-1:0]     tmr_val;
   logic              sr_load, sr_shift;
   logic [WORD_W-1:0] ref_w, cnt_w, load_w;
   logic [R_W-1:0]    fmt_r;
   logic [N_W-1:0]    fmt_n;
   logic [A_W-1:0]    fmt_a;

   assign accept   = (ph == PH_IDLE) && start && (want_ref || want_cnt);
   assign last_bit = (bit_idx == BIT_W'(WORD_W - 1));

   // while idle the live inputs feed the formatter, afterwards the captured ones
   assign fmt_r = (ph == PH_IDLE) ? ref_div  : r_q;
   assign fmt_n = (ph == PH_IDLE) ? main_div : n_q;
   assign fmt_a = (ph == PH_IDLE) ? swal_div : a_q;

   spw_word_fmt #(.R_W(R_W), .N_W(N_W), .A_W(A_W)) u_fmt (
      .r_val(fmt_r), .n_val(fmt_n), .a_val(fmt_a),
      .ref_word(ref_w), .cnt_word(cnt_w)
   );

   assign sr_load  = accept || ((ph == PH_LATCH) && expired && pend);
   assign load_w   = (accept && want_ref) ? ref_w : cnt_w;
   assign sr_shift = (ph == PH_HIGH) && expired && !last_bit;

   spw_shreg #(.W(WORD_W)) u_sr (
      .clk(clk), .rst_n(rst_n), .load(sr_load), .shift(sr_shift),
      .word(load_w), .msb(sdata)
   );

   assign tmr_load = accept || (expired && (ph != PH_IDLE));

   always_comb begin
      unique case (ph)
         PH_SETUP: tmr_val = TW'(CHI_CYC - 1);
         PH_HIGH:  tmr_val = last_bit ? TW'(GAP_CYC - 1) : TW'(DSU_CYC - 1);
         PH_GAP:   tmr_val = TW'(LE_CYC - 1);
         default:  tmr_val = TW'(DSU_CYC - 1);
      endcase
   end

   spw_interval #(.TW(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .expired(expired)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph      <= PH_IDLE;
         bit_idx <= '0;
         pend    <= 1'b0;
         r_q     <= '0;
         n_q     <= '0;
         a_q     <= '0;
         sclk_q  <= 1'b0;
         sle_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (ph)
            PH_IDLE: if (accept) begin
               r_q     <= ref_div;
               n_q     <= main_div;
               a_q     <= swal_div;
               pend    <= want_ref && want_cnt;
               bit_idx <= '0;
               ph      <= PH_SETUP;
            end
            PH_SETUP: if (expired) begin
               sclk_q <= 1'b1;
               ph     <= PH_HIGH;
            end
            PH_HIGH: if (expired) begin
               sclk_q <= 1'b0;
               if (last_bit) ph <= PH_GAP;
               else begin
                  bit_idx <= bit_idx + 1'b1;
                  ph      <= PH_SETUP;
               end
            end
            PH_GAP: if (expired) begin
               sle_q <= 1'b1;
               ph    <= PH_LATCH;
            end
            PH_LATCH: if (expired) begin
               sle_q   <= 1'b0;
               done_q  <= 1'b1;
               bit_idx <= '0;
               if (pend) begin
                  pend <= 1'b0;
                  ph   <= PH_SETUP;
               end else begin
                  ph <= PH_IDLE;
               end
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assign sclk = sclk_q;
   assign sle  = sle_q;
   assign done = done_q;
   assign busy = (ph != PH_IDLE);
endmodule

// File: rtl/spw_checker.sv
module spw_checker (
   input logic clk,
   input logic rst_n,
   input logic sclk,
   input logic sdata,
   input logic sle,
   input logic busy,
   input logic done
);
   AST_STROBE_CLK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      sle |-> !sclk);                                                   // R4
   AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(sdata));                        // R5
   AST_DATA_SET_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> $stable(sdata));                                  // R5
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                  // R10
   AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(sle) && !sle));                                   // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!sclk && !sle));                                       // R11
endmodule

bind synth_word_loader spw_checker u_chk (
   .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata),
   .sle(sle), .busy(busy), .done(done)
);

// File: tb/synth_word_loader_tb.sv
module synth_word_loader_tb;
   localparam int DSU = 3, CHI = 2, GAP = 4, LEC = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 1'b0, want_ref = 1'b0, want_cnt = 1'b0;
   logic [13:0] ref_div = '0;
   logic [10:0] main_div = '0;
   logic [6:0]  swal_div = '0;
   logic sclk, sdata, sle, busy, done;

   always #10 clk = ~clk;

   synth_word_loader #(.DSU_CYC(DSU), .CHI_CYC(CHI), .GAP_CYC(GAP), .LE_CYC(LEC)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .want_ref(want_ref), .want_cnt(want_cnt),
      .ref_div(ref_div), .main_div(main_div), .swal_div(swal_div),
      .sclk(sclk), .sdata(sdata), .sle(sle), .busy(busy), .done(done)
   );

   int n_chk = 0, n_bad = 0;
   int cyc = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- link monitor ----------------
   logic [18:0] got_w [0:255];
   int   got_n = 0, done_n = 0, rise_n = 0;
   logic [18:0] shw = '0;
   int   nbits = 0, low_run = 0, high_run = 0, data_age = 0, since_fall = 0, le_run = 0;
   logic p_sclk = 1'b0, p_sle = 1'b0, p_sdata = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         data_age = (sdata != p_sdata) ? 1 : data_age + 1;
         if (sclk && !p_sclk) begin
            chk(low_run >= DSU, "R5 low time", low_run, DSU);
            chk(data_age > DSU, "R5 data setup", data_age, DSU + 1);
            chk(!sle, "R4 strobe during shift", sle, 0);
            shw = {shw[17:0], sdata};
            nbits++;
            rise_n++;
         end
         if (sclk && p_sclk) chk(sdata == p_sdata, "R5 data held", sdata, p_sdata);
         if (!sclk && p_sclk) chk(high_run == CHI, "R5 high time", high_run, CHI);
         if (sle && !p_sle) begin
            chk(nbits == 19, "R4 bit count", nbits, 19);
            chk(since_fall >= GAP, "R6 gap", since_fall, GAP);
            got_w[got_n[7:0]] = shw;
            got_n++;
            nbits = 0;
         end
         if (!sle && p_sle) chk(le_run == LEC, "R6 strobe width", le_run, LEC);
         if (done) begin
            chk(p_sle && !sle, "R10 done placement", {p_sle, sle}, 2);
            done_n++;
         end
         if (sclk) begin high_run = p_sclk ? high_run + 1 : 1; low_run = 0; end
         else      begin low_run  = p_sclk ? 1 : low_run + 1; end
         since_fall = (!sclk && p_sclk) ? 1 : since_fall + 1;
         le_run = sle ? (p_sle ? le_run + 1 : 1) : 0;
      end
      p_sclk = sclk; p_sle = sle; p_sdata = sdata;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_bad++;
         $display("FAIL R11 watchdog busy=%0d expected 0", busy);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   function automatic logic [18:0] ref_exp(input logic [13:0] r);
      return {1'b0, 1'b0, 1'b1, 1'b0, r, 1'b1};
   endfunction
   function automatic logic [18:0] cnt_exp(input logic [10:0] n, input logic [6:0] a);
      return {n, a, 1'b0};
   endfunction

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic xfer(input bit wr, input bit wc, input logic [13:0] r,
                       input logic [10:0] n, input logic [6:0] a, input bit poke);
      int g0, d0, k;
      g0 = got_n; d0 = done_n; k = int'(wr) + int'(wc);
      @(negedge clk);
      start = 1'b1; want_ref = wr; want_cnt = wc;
      ref_div = r; main_div = n; swal_div = a;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R11 busy after start", busy, 1);
      if (poke) begin
         repeat (7) @(negedge clk);
         start = 1'b1; want_ref = 1'b1; want_cnt = 1'b1;
         ref_div = ~r; main_div = ~n; swal_div = ~a;
         @(negedge clk);
         start = 1'b0;
      end
      wait_idle();
      chk(done == 1'b1, "R11 done with busy fall", done, 1);
      @(negedge clk);
      chk(done == 1'b0, "R10 done one cycle", done, 0);
      chk(got_n == g0 + k, poke ? "R8 word count" : "R4 word count", got_n - g0, k);
      chk(done_n == d0 + k, "R10 done count", done_n - d0, k);
      if (wr) chk(got_w[g0[7:0]] == ref_exp(r), wc ? "R7 R2 ref first" : "R2 ref word",
                  got_w[g0[7:0]], ref_exp(r));
      if (wc) chk(got_w[(g0 + int'(wr)) & 255] == cnt_exp(n, a),
                  wr ? "R7 R3 cnt second" : "R3 cnt word",
                  got_w[(g0 + int'(wr)) & 255], cnt_exp(n, a));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk({sclk, sdata, sle, busy, done} == 5'b0, "R1 in reset", {sclk, sdata, sle, busy, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({sclk, sdata, sle, busy, done} == 5'b0, "R1 after reset", {sclk, sdata, sle, busy, done}, 0);

      // worked example, both words
      xfer(1'b1, 1'b1, 14'd850, 11'd274, 7'd17, 1'b0);

      // sweep values across all three request modes
      for (int i = 0; i < 6; i++) begin
         for (int m = 0; m < 3; m++) begin
            logic [13:0] r;
            logic [10:0] n;
            logic [6:0]  a;
            r = (i == 0) ? 14'h0000 : (i == 1) ? 14'h3FFF : 14'(850 + i * 2777);
            n = (i == 0) ? 11'h7FF  : (i == 1) ? 11'h000  : 11'(274 + i * 311);
            a = (i == 0) ? 7'h7F    : (i == 1) ? 7'h00    : 7'(17 + i * 29);
            xfer(m != 1, m != 0, r, n, a, 1'b0);
         end
      end

      // start during busy with altered values (R8)
      xfer(1'b1, 1'b0, 14'h1555, 11'h2AA, 7'h55, 1'b1);
      xfer(1'b1, 1'b1, 14'h2AAA, 11'h555, 7'h2A, 1'b1);

      // start with nothing selected (R9)
      begin
         int g0, r0;
         g0 = got_n; r0 = rise_n;
         @(negedge clk);
         start = 1'b1; want_ref = 1'b0; want_cnt = 1'b0;
         @(negedge clk);
         start = 1'b0;
         chk(busy == 1'b0, "R9 busy stays low", busy, 0);
         repeat (12) @(negedge clk);
         chk(rise_n == r0, "R9 no clock edges", rise_n - r0, 0);
         chk(got_n == g0, "R9 no words", got_n - g0, 0);
      end

      // new start in the completion cycle (R11)
      begin
         int g0;
         g0 = got_n;
         @(negedge clk);
         start = 1'b1; want_ref = 1'b0; want_cnt = 1'b1;
         main_div = 11'h123; swal_div = 7'h45;
         @(negedge clk);
         start = 1'b0;
         wait_idle();
         chk(done == 1'b1, "R11 done at completion", done, 1);
         start = 1'b1; want_ref = 1'b1; want_cnt = 1'b0; ref_div = 14'h0F0F;
         @(negedge clk);
         start = 1'b0;
         chk(busy == 1'b1, "R11 start taken in done cycle", busy, 1);
         wait_idle();
         @(negedge clk);
         chk(got_n == g0 + 2, "R11 both requests sent", got_n - g0, 2);
         chk(got_w[g0[7:0]] == cnt_exp(11'h123, 7'h45), "R3 first request",
             got_w[g0[7:0]], cnt_exp(11'h123, 7'h45));
         chk(got_w[(g0 + 1) & 255] == ref_exp(14'h0F0F), "R2 second request",
             got_w[(g0 + 1) & 255], ref_exp(14'h0F0F));
      end

      repeat (4) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule